// File: doc/BRIEF.md
# Iterative Popcount and Parity Core

This block counts the set bits of a data word by walking it one bit per clock. It shifts the word right and adds the bit that falls out. It stops as soon as the remaining word is zero. The count is then presented together with a one-bit odd-parity flag, and is held there until the consumer acknowledges it.

Both ends of a transaction use a request/acknowledge pair. A producer raises `req_start` with the word on `din` and keeps both until `start_ack` pulses. The core signals completion with `done` and waits for `done_ack` before it returns to idle. The run time depends on the data: a word whose highest set bit sits at position p needs p+1 shift cycles. A zero word needs exactly one shift cycle.

Top module: `popcount_handshake_core`

## Requirements
- R1: While `rst` is high at a rising edge, the core returns to idle. After that edge `start_ack` and `done` are both 0 and `cnt_out` reads 0.
- R2: In idle with `req_start` at 1 at a rising edge, `start_ack` is 1 for exactly the following cycle. In idle with `req_start` at 0, `start_ack` and `done` stay 0.
- R3: `din` is captured at the rising edge that ends the `start_ack` cycle. Changes on `din` after that edge have no effect on the result.
- R4: When `done` is 1, `cnt_out` equals the number of 1 bits in the captured word, as an unsigned binary value of WIDTH bits.
- R5: `done` rises n+1 cycles after the cycle in which `start_ack` is 1. Here n is the index of the highest set bit plus one, with bit 0 as the least significant bit.
- R6: A zero word reports `cnt_out` = 0. Its `done` rises 2 cycles after the `start_ack` cycle.
- R7: While `done` is 1 and `done_ack` is 0, `done` stays 1 and `cnt_out` keeps its value.
- R8: A rising edge with `done` at 1 and `done_ack` at 1 returns the core to idle. `done` is 0 in the next cycle and `cnt_out` reads 0.
- R9: While `done` is 1, `ones_odd` equals bit 0 of `cnt_out`. Outside `done` it is 0.
- R10: `start_ack` and `done` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_start | input | 1 | Start request |
| din | input | WIDTH | Word to be counted |
| start_ack | output | 1 | One-cycle acknowledge of the start request |
| cnt_out | output | WIDTH | Bit count, valid while done is 1, else 0 |
| done | output | 1 | Result available |
| done_ack | input | 1 | Consumer acknowledge of the result |
| ones_odd | output | 1 | 1 when the count is odd, valid with done |

## Verification
The start acknowledge is due one cycle after the request. The result appears n+1 cycles after the acknowledge, where n is the length of the word up to its highest set bit. The drop of `done` is due one cycle after `done_ack`. The bench drives and samples on the falling edge, so every expected cycle lands on a falling-edge sample. It counts the samples between `start_ack` and `done` and compares that count with a figure derived from the word's highest set bit. It also holds `done_ack` low for several samples to observe that the result stays put. It then alters `din` right after capture to show that the alteration cannot reach the count.

// File: rtl/popcount_handshake_core.sv
module popcount_handshake_core #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_start,
  input  logic [WIDTH-1:0] din,
  output logic             start_ack,
  output logic [WIDTH-1:0] cnt_out,
  output logic             done,
  input  logic             done_ack,
  output logic             ones_odd
);

  typedef enum logic [1:0] {IDLE, GRAB, SHIFT, HOLD} phase_t;

  phase_t           phase;
  logic [WIDTH-1:0] work;
  logic [WIDTH-1:0] tally;
  logic [WIDTH-1:0] work_next;

  assign work_next = work >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= IDLE;
    end else begin
      case (phase)
        IDLE:    if (req_start) phase <= GRAB;
        GRAB:    phase <= SHIFT;
        SHIFT:   if (work_next == '0) phase <= HOLD;
        HOLD:    if (done_ack) phase <= IDLE;
        default: phase <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      work  <= '0;
      tally <= '0;
    end else if (phase == GRAB) begin
      work  <= din;
      tally <= '0;
    end else if (phase == SHIFT) begin
      work  <= work_next;
      tally <= tally + {{(WIDTH-1){1'b0}}, work[0]};
    end
  end

  assign start_ack = (phase == GRAB);
  assign done      = (phase == HOLD);
  assign cnt_out   = done ? tally : '0;
  assign ones_odd  = done & tally[0];

endmodule

module popcount_handshake_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             start_ack,
  input logic             done,
  input logic             done_ack,
  input logic [WIDTH-1:0] cnt_out,
  input logic             ones_odd
);

  // R2
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    start_ack |=> !start_ack);

  // R6
  min_latency_chk: assert property (@(posedge clk) disable iff (rst)
    start_ack |=> !done);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !done_ack) |=> (done && $stable(cnt_out)));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (done && done_ack) |=> !done);

  // R9
  parity_chk: assert property (@(posedge clk) disable iff (rst)
    ones_odd |-> (done && cnt_out[0]));

  // R10
  exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(start_ack && done));

endmodule

bind popcount_handshake_core popcount_handshake_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .start_ack(start_ack), .done(done),
  .done_ack(done_ack), .cnt_out(cnt_out), .ones_odd(ones_odd)
);

// File: tb/popcount_handshake_core_test.sv
module popcount_handshake_core_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_start = 1'b0;
  logic [W-1:0] din = '0;
  logic         start_ack;
  logic [W-1:0] cnt_out;
  logic         done;
  logic         done_ack = 1'b0;
  logic         ones_odd;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  popcount_handshake_core #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .req_start(req_start), .din(din),
    .start_ack(start_ack), .cnt_out(cnt_out), .done(done),
    .done_ack(done_ack), .ones_odd(ones_odd)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_ones(input logic [W-1:0] w);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(w[i]);
    return n;
  endfunction

  function automatic int ref_len(input logic [W-1:0] w);
    int n = 1;
    for (int i = 0; i < W; i++) if (w[i]) n = i + 1;
    return n;
  endfunction

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 start_ack", start_ack, 0);
    check("R1 done", done, 0);
    check("R1 cnt_out", cnt_out, 0);
    rst = 1'b0;
  endtask

  task automatic test_idle();
    int seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (start_ack || done) seen++;
    end
    check("R2 idle stays quiet", seen, 0);
  endtask

  task automatic run_word(input logic [W-1:0] w);
    int lat = 0;
    int stable_bad = 0;
    logic [W-1:0] held;
    @(negedge clk);
    req_start = 1'b1;
    din = w;
    @(negedge clk);
    check("R2 start_ack one cycle after request", start_ack, 1);
    req_start = 1'b0;
    @(negedge clk);
    din = ~w;
    check("R2 start_ack single pulse", start_ack, 0);
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check("R5 latency", lat, ref_len(w) + 1);
    check("R4 R3 count", cnt_out, ref_ones(w));
    check("R9 parity", ones_odd, ref_ones(w) % 2);
    if (w == '0) check("R6 zero word latency", lat, 2);
    held = cnt_out;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (!done || cnt_out != held) stable_bad++;
    end
    check("R7 hold until ack", stable_bad, 0);
    done_ack = 1'b1;
    @(negedge clk);
    done_ack = 1'b0;
    check("R8 done drops", done, 0);
    check("R8 cnt_out cleared", cnt_out, 0);
    check("R9 parity cleared", ones_odd, 0);
  endtask

  initial begin
    test_reset();
    test_idle();
    run_word('0);
    run_word('1);
    run_word(32'h0000_0001);
    run_word(32'h8000_0000);
    run_word(32'h0000_0020);
    run_word(32'hAAAA_AAAA);
    run_word(32'h5555_5555);
    run_word(32'h0001_0003);
    for (int k = 0; k < 20; k++) run_word($urandom);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule